// File: doc/BRIEF.md
# Single-Level 2D Wavelet Tile Engine

This block performs one level of two-dimensional wavelet decomposition on a square tile of 8-bit pixels, 8x8 by default. Software or an upstream stage writes the pixels into an internal tile buffer through a simple write port and then pulses `start`. A horizontal filter engine processes one whole row per clock. For each row it produces a low band and a high band, each half the width of the row, and stores them in two intermediate buffers.

Two vertical filter engines then run side by side, one over the low band and one over the high band. A reorder stage feeds each engine one intermediate column per clock. The four resulting subbands are written into an output coefficient map, and `done` rises. The coefficients can then be read back through a registered read port.

Each filter engine uses a symmetric 9-tap low-pass and 7-tap high-pass kernel. Matching samples on either side of the centre are added before weighting, and every weight is applied as a sum of shifted copies of the operand, so no multipliers are built. Tile edges use mirror extension. A tag travels with each vector through every filter engine, so the control logic knows which buffer row or column a result belongs to.

Top module: `wavelet2d_tile`

## Requirements
- R1: While `rst_n` is low, `done` reads 0 and `rd_data` reads 0.
- R2: A pulse on `pix_we` while the engine is idle stores `pix_data` as the unsigned pixel at row `pix_addr[5:3]`, column `pix_addr[2:0]`.
- R3: With default parameters, `done` rises exactly 14 clock edges after the edge that samples `start` high while idle, and it stays low while a run is in progress.
- R4: Low-pass weights, from the centre outward, are 224, 96, -28, -6 and 10. Low output i is centred on sample 2i, and indices outside the tile are mirrored (index -j maps to j, index 7+j maps to 7-j). Each pass divides its weighted sum by 256 with floor rounding, that is, an arithmetic right shift by 8.
- R5: High-pass weights, from the centre outward, are -208, 112, 8 and -16. High output i is centred on sample 2i+1, with the same mirroring and the same shift by 8 as in R4.
- R6: In the output map, `rd_addr[5:3]` is the coefficient row and `rd_addr[2:0]` is the column. Rows 0-3 hold vertical-low results and rows 4-7 hold vertical-high results. Columns 0-3 hold horizontal-low results and columns 4-7 hold horizontal-high results. This places LL top-left, HL top-right, LH bottom-left and HH bottom-right.
- R7: While a run is in progress, `start` pulses and pixel writes are ignored. The result and the completion time are those of the tile that was loaded before the run began.
- R8: `done` stays high until `start` is sampled again, and it goes low on that edge. `rd_data` shows the map entry at `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_we | input | 1 | Pixel write strobe |
| pix_addr | input | 6 | Pixel location {row, column} |
| pix_data | input | 8 | Unsigned pixel value |
| start | input | 1 | Begin a decomposition run |
| done | output | 1 | All coefficients written to the output map |
| rd_addr | input | 6 | Coefficient location {row, column} |
| rd_data | output | 16 | Signed coefficient, one clock after `rd_addr` |

## Verification
The engine is run on nine tiles, and the bench checks all 64 coefficients of each run against a model that applies the stated weights arithmetically.

- A flat tile and a full-scale tile test the DC gain of both kernels, the zero response of the high-pass kernel and the rounding toward minus infinity.
- Single-pixel impulses at a corner and in the interior expose each weight separately, along with the mirror extension at the tile edges and any error in pixel or quadrant addressing.
- Horizontal and vertical ramps, a checkerboard, a diagonal and a pseudo-random tile separate the row direction from the column direction and mix the signs of the coefficients.
- One ramp run is disturbed by pixel writes and an extra `start`, to show that the tile buffer and the timing are locked while the engine is busy.

// File: rtl/dwt2d_pkg.sv
package dwt2d_pkg;

   // Number of distinct weights in each symmetric kernel (centre plus one side).
   localparam int LO_TAPS    = 5;
   localparam int HI_TAPS    = 4;
   localparam int COEF_SHIFT = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_RWAIT,
      ST_COL,
      ST_CWAIT
   } dwt_state_e;

   // Low-pass weight at distance d from the centre.
   function automatic int lo_coef(input int d);
      case (d)
         0:       return 224;
         1:       return 96;
         2:       return -28;
         3:       return -6;
         4:       return 10;
         default: return 0;
      endcase
   endfunction

   // High-pass weight at distance d from the centre.
   function automatic int hi_coef(input int d);
      case (d)
         0:       return -208;
         1:       return 112;
         2:       return 8;
         3:       return -16;
         default: return 0;
      endcase
   endfunction

   // Whole-sample mirror extension at both tile edges.
   function automatic int mirror(input int j, input int n);
      if (j < 0)      return -j;
      else if (j > n - 1) return 2 * (n - 1) - j;
      else            return j;
   endfunction

endpackage

// File: rtl/dwt2d_lane.sv
module dwt2d_lane
   import dwt2d_pkg::*;
#(
   parameter int N       = 8,
   parameter int CW      = 16,
   parameter int TW      = 3,
   parameter int PRE_REG = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [TW-1:0]        in_tag,
   input  logic signed [CW-1:0] in_vec  [N],
   output logic                 out_valid,
   output logic [TW-1:0]        out_tag,
   output logic signed [CW-1:0] out_lo  [N/2],
   output logic signed [CW-1:0] out_hi  [N/2]
);

   localparam int H  = N / 2;
   localparam int AW = CW + 12;

   // Weight a value by a constant using shifted copies only.
   function automatic logic signed [AW-1:0] shmul(input logic signed [AW-1:0] x,
                                                  input int k);
      logic signed [AW-1:0] r;
      int m;
      r = '0;
      m = (k < 0) ? -k : k;
      for (int b = 0; b < 10; b++)
         if (m[b]) r = r + (x <<< b);
      return (k < 0) ? -r : r;
   endfunction

   logic signed [CW:0] xe [N];
   logic signed [CW:0] lo_pair   [H][LO_TAPS];
   logic signed [CW:0] hi_pair   [H][HI_TAPS];
   logic signed [CW:0] lo_pair_s [H][LO_TAPS];
   logic signed [CW:0] hi_pair_s [H][HI_TAPS];
   logic               v_s;
   logic [TW-1:0]      t_s;
   logic signed [AW-1:0] lo_acc [H];
   logic signed [AW-1:0] hi_acc [H];

   genvar j, i, d;
   generate
      for (j = 0; j < N; j++) begin : g_ext
         assign xe[j] = (CW+1)'(in_vec[j]);
      end

      // Symmetric pre-add: samples at equal distance share one weight.
      for (i = 0; i < H; i++) begin : g_out
         for (d = 0; d < LO_TAPS; d++) begin : g_lo
            if (d == 0) begin : g_c
               assign lo_pair[i][d] = xe[2*i];
            end else begin : g_p
               localparam int A = mirror(2*i - d, N);
               localparam int B = mirror(2*i + d, N);
               assign lo_pair[i][d] = xe[A] + xe[B];
            end
         end
         for (d = 0; d < HI_TAPS; d++) begin : g_hi
            if (d == 0) begin : g_c
               assign hi_pair[i][d] = xe[2*i+1];
            end else begin : g_p
               localparam int A = mirror(2*i + 1 - d, N);
               localparam int B = mirror(2*i + 1 + d, N);
               assign hi_pair[i][d] = xe[A] + xe[B];
            end
         end
      end

      // Optional register after the pre-add stage.
      if (PRE_REG != 0) begin : g_pre
         always_ff @(posedge clk) begin
            if (!rst_n) v_s <= 1'b0;
            else        v_s <= in_valid;
            t_s       <= in_tag;
            lo_pair_s <= lo_pair;
            hi_pair_s <= hi_pair;
         end
      end else begin : g_nopre
         assign v_s       = in_valid;
         assign t_s       = in_tag;
         assign lo_pair_s = lo_pair;
         assign hi_pair_s = hi_pair;
      end
   endgenerate

   always_comb begin
      for (int o = 0; o < H; o++) begin
         lo_acc[o] = '0;
         hi_acc[o] = '0;
         for (int k = 0; k < LO_TAPS; k++)
            lo_acc[o] = lo_acc[o] + shmul(AW'(lo_pair_s[o][k]), lo_coef(k));
         for (int k = 0; k < HI_TAPS; k++)
            hi_acc[o] = hi_acc[o] + shmul(AW'(hi_pair_s[o][k]), hi_coef(k));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= v_s;
      out_tag <= t_s;
      for (int o = 0; o < H; o++) begin
         out_lo[o] <= lo_acc[o][COEF_SHIFT +: CW];
         out_hi[o] <= hi_acc[o][COEF_SHIFT +: CW];
      end
   end

endmodule

// File: rtl/wavelet2d_tile.sv
module wavelet2d_tile
   import dwt2d_pkg::*;
#(
   parameter  int N       = 8,
   parameter  int PW      = 8,
   parameter  int CW      = 16,
   parameter  int PRE_REG = 0,
   localparam int AW      = $clog2(N * N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_we,
   input  logic [AW-1:0] pix_addr,
   input  logic [PW-1:0] pix_data,
   input  logic          start,
   output logic          done,
   input  logic [AW-1:0] rd_addr,
   output logic [CW-1:0] rd_data
);

   localparam int H  = N / 2;
   localparam int TW = $clog2(N);

   generate
      if ((N & (N - 1)) != 0 || N < 8) begin : g_bad_n
         $error("tile size must be a power of two of at least 8");
      end
      if (PRE_REG != 0 && PRE_REG != 1) begin : g_bad_pre
         $error("PRE_REG must be 0 or 1");
      end
      if (CW < PW + 4) begin : g_bad_cw
         $error("coefficient width too small for pixel width");
      end
   endgenerate

   dwt_state_e    st;
   logic [TW-1:0] cnt;
   logic          busy;

   logic [PW-1:0]        pix_mem [N*N];
   logic signed [CW-1:0] lmem    [N][H];
   logic signed [CW-1:0] hmem    [N][H];
   logic signed [CW-1:0] omem    [N*N];

   logic signed [CW-1:0] rw_vec [N];
   logic signed [CW-1:0] cl_vec [N];
   logic signed [CW-1:0] ch_vec [N];
   logic                 rw_ov, cl_ov, ch_ov;
   logic [TW-1:0]        rw_ot;
   logic [TW-2:0]        cl_ot, ch_ot;
   logic signed [CW-1:0] rw_lo [H], rw_hi [H];
   logic signed [CW-1:0] cl_lo [H], cl_hi [H];
   logic signed [CW-1:0] ch_lo [H], ch_hi [H];

   assign busy = (st != ST_IDLE);

   // Tile buffer: locked while a run is in progress.
   always_ff @(posedge clk) begin
      if (pix_we && !busy) pix_mem[pix_addr] <= pix_data;
   end

   // Row feed and column reorder.
   genvar j;
   generate
      for (j = 0; j < N; j++) begin : g_feed
         assign rw_vec[j] = {{(CW-PW){1'b0}}, pix_mem[{cnt, TW'(j)}]};
         assign cl_vec[j] = lmem[j][cnt[TW-2:0]];
         assign ch_vec[j] = hmem[j][cnt[TW-2:0]];
      end
   endgenerate

   dwt2d_lane #(.N(N), .CW(CW), .TW(TW), .PRE_REG(PRE_REG)) u_row (
      .clk(clk), .rst_n(rst_n),
      .in_valid(st == ST_ROW), .in_tag(cnt), .in_vec(rw_vec),
      .out_valid(rw_ov), .out_tag(rw_ot), .out_lo(rw_lo), .out_hi(rw_hi)
   );

   dwt2d_lane #(.N(N), .CW(CW), .TW(TW-1), .PRE_REG(PRE_REG)) u_col_lo (
      .clk(clk), .rst_n(rst_n),
      .in_valid(st == ST_COL), .in_tag(cnt[TW-2:0]), .in_vec(cl_vec),
      .out_valid(cl_ov), .out_tag(cl_ot), .out_lo(cl_lo), .out_hi(cl_hi)
   );

   dwt2d_lane #(.N(N), .CW(CW), .TW(TW-1), .PRE_REG(PRE_REG)) u_col_hi (
      .clk(clk), .rst_n(rst_n),
      .in_valid(st == ST_COL), .in_tag(cnt[TW-2:0]), .in_vec(ch_vec),
      .out_valid(ch_ov), .out_tag(ch_ot), .out_lo(ch_lo), .out_hi(ch_hi)
   );

   // Write-back steered by the tag that travelled with each vector.
   always_ff @(posedge clk) begin
      if (rw_ov) begin
         for (int i = 0; i < H; i++) begin
            lmem[rw_ot][i] <= rw_lo[i];
            hmem[rw_ot][i] <= rw_hi[i];
         end
      end
      if (cl_ov) begin
         for (int k = 0; k < H; k++) begin
            omem[{1'b0, (TW-1)'(k), 1'b0, cl_ot}] <= cl_lo[k];
            omem[{1'b1, (TW-1)'(k), 1'b0, cl_ot}] <= cl_hi[k];
         end
      end
      if (ch_ov) begin
         for (int k = 0; k < H; k++) begin
            omem[{1'b0, (TW-1)'(k), 1'b1, ch_ot}] <= ch_lo[k];
            omem[{1'b1, (TW-1)'(k), 1'b1, ch_ot}] <= ch_hi[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               st   <= ST_ROW;
               cnt  <= '0;
               done <= 1'b0;
            end
            ST_ROW: begin
               cnt <= cnt + 1'b1;
               if (cnt == TW'(N - 1)) st <= ST_RWAIT;
            end
            ST_RWAIT: if (rw_ov && rw_ot == TW'(N - 1)) begin
               st  <= ST_COL;
               cnt <= '0;
            end
            ST_COL: begin
               if (cnt == TW'(H - 1)) begin
                  st  <= ST_CWAIT;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CWAIT: if (cl_ov && cl_ot == (TW-1)'(H - 1)) begin
               st   <= ST_IDLE;
               done <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= omem[rd_addr];
   end

endmodule

// File: rtl/dwt2d_sva.sv
module dwt2d_sva #(
   parameter int N       = 8,
   parameter int PRE_REG = 0,
   parameter int AW      = 6,
   parameter int CW      = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          done,
   input logic          busy,
   input logic [AW-1:0] rd_addr,
   input logic [CW-1:0] rd_data
);

   localparam int RUN = N + N / 2 + 2 * (1 + PRE_REG);

   logic [15:0] cyc;

   always_ff @(posedge clk) begin
      if (!rst_n)              cyc <= '0;
      else if (start && !busy) cyc <= '0;
      else if (busy)           cyc <= cyc + 16'd1;
   end

   // R3: completion lands a fixed number of edges after the accepted start.
   p_run_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (cyc == 16'(RUN)));

   // R3: no completion flag during a run.
   p_idle_when_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   // R8: an accepted start clears the flag.
   p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> !done);

   // R8: the flag holds until the next start.
   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R8: with the map settled and the address held, read data does not move.
   p_rd_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done) && $stable(rd_addr)) |=> $stable(rd_data));

endmodule

bind wavelet2d_tile dwt2d_sva #(.N(N), .PRE_REG(PRE_REG), .AW(AW), .CW(CW)) u_sva (
   .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
   .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_wavelet2d_tile.sv
`timescale 1ns/1ps
module sim_wavelet2d_tile;

   localparam int N   = 8;
   localparam int H   = 4;
   localparam int RUN = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_we = 1'b0;
   logic [5:0]  pix_addr = '0;
   logic [7:0]  pix_data = '0;
   logic        start = 1'b0;
   logic        done;
   logic [5:0]  rd_addr = '0;
   logic [15:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;
   int tile [64];
   int expv [64];

   always #2 clk = ~clk;

   wavelet2d_tile u0 (
      .clk(clk), .rst_n(rst_n), .pix_we(pix_we), .pix_addr(pix_addr),
      .pix_data(pix_data), .start(start), .done(done),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int mir(input int j);
      if (j < 0)     return -j;
      if (j > N - 1) return 2 * (N - 1) - j;
      return j;
   endfunction

   function automatic int wlo(input int d);
      int w [5] = '{224, 96, -28, -6, 10};
      return w[d];
   endfunction

   function automatic int whi(input int d);
      int w [4] = '{-208, 112, 8, -16};
      return w[d];
   endfunction

   // R4: low-pass reference
   function automatic int flo(input int v [8], input int i);
      int s = 0;
      for (int k = -4; k <= 4; k++) s += wlo(k < 0 ? -k : k) * v[mir(2*i + k)];
      return s >>> 8;
   endfunction

   // R5: high-pass reference
   function automatic int fhi(input int v [8], input int i);
      int s = 0;
      for (int k = -3; k <= 3; k++) s += whi(k < 0 ? -k : k) * v[mir(2*i + 1 + k)];
      return s >>> 8;
   endfunction

   task automatic build_model();
      int rl [8][4];
      int rh [8][4];
      for (int r = 0; r < N; r++) begin
         int v [8];
         for (int c = 0; c < N; c++) v[c] = tile[r*N + c];
         for (int i = 0; i < H; i++) begin
            rl[r][i] = flo(v, i);
            rh[r][i] = fhi(v, i);
         end
      end
      for (int c = 0; c < H; c++) begin
         int a [8];
         int b [8];
         for (int r = 0; r < N; r++) begin
            a[r] = rl[r][c];
            b[r] = rh[r][c];
         end
         // R6: quadrant placement
         for (int k = 0; k < H; k++) begin
            expv[k*N + c]           = flo(a, k);
            expv[(H+k)*N + c]       = fhi(a, k);
            expv[k*N + H + c]       = flo(b, k);
            expv[(H+k)*N + H + c]   = fhi(b, k);
         end
      end
   endtask

   task automatic run_tile(input string tname, input bit disturb, input bit after_done);
      bit got;
      // R2: load pixels at {row, column}
      for (int a = 0; a < 64; a++) begin
         @(negedge clk);
         pix_we   = 1'b1;
         pix_addr = 6'(a);
         pix_data = 8'(tile[a]);
      end
      @(negedge clk);
      pix_we = 1'b0;
      build_model();
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (after_done) check(done == 1'b0, {"R8 start clears done ", tname}, int'(done), 0);
      got = 1'b0;
      for (int k = 1; k <= 200 && !got; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (done) begin
            got = 1'b1;
            check(k == RUN, {"R3 run length ", tname}, k, RUN);
         end else if (disturb && k <= 4) begin
            // R7: writes and a second start while busy
            pix_we   = 1'b1;
            pix_addr = 6'(k * 9);
            pix_data = 8'(tile[k*9]) ^ 8'hA5;
            start    = (k == 2);
         end else begin
            pix_we = 1'b0;
            start  = 1'b0;
         end
      end
      pix_we = 1'b0;
      start  = 1'b0;
      if (!got) check(1'b0, {"R3 timeout ", tname}, 0, RUN);
      repeat (3) @(negedge clk);
      check(done == 1'b1, {"R8 done holds ", tname}, int'(done), 1);
      for (int a = 0; a < 64; a++) begin
         string q;
         rd_addr = 6'(a);
         @(negedge clk);
         q = ((a / N) < H && (a % N) < H) ? "R4 R6" : "R5 R6";
         check(int'($signed(rd_data)) == expv[a],
               $sformatf("%s %s coef %0d", q, tname, a), int'($signed(rd_data)), expv[a]);
      end
   endtask

   initial begin
      int s;
      repeat (4) @(negedge clk);
      // R1: reset state
      check(done == 1'b0, "R1 done in reset", int'(done), 0);
      check(rd_data == 16'd0, "R1 rd_data in reset", int'(rd_data), 0);
      rst_n = 1'b1;

      for (int a = 0; a < 64; a++) tile[a] = 200;
      run_tile("flat", 1'b0, 1'b0);

      for (int a = 0; a < 64; a++) tile[a] = (a == 0) ? 255 : 0;
      run_tile("R2 corner impulse", 1'b0, 1'b1);

      for (int a = 0; a < 64; a++) tile[a] = (a == 3*N + 5) ? 255 : 0;
      run_tile("R2 inner impulse", 1'b0, 1'b1);

      for (int a = 0; a < 64; a++) tile[a] = 32 * (a % N);
      run_tile("R7 row ramp disturbed", 1'b1, 1'b1);

      for (int a = 0; a < 64; a++) tile[a] = 30 * (a / N) + 5;
      run_tile("column ramp", 1'b0, 1'b1);

      for (int a = 0; a < 64; a++) tile[a] = (((a / N) + (a % N)) % 2 == 1) ? 255 : 0;
      run_tile("checker", 1'b0, 1'b1);

      s = 32'h1234;
      for (int a = 0; a < 64; a++) begin
         s = s * 1103515245 + 12345;
         tile[a] = (s >>> 16) & 255;
      end
      run_tile("pseudo random", 1'b0, 1'b1);

      for (int a = 0; a < 64; a++) tile[a] = 255;
      run_tile("full scale", 1'b0, 1'b1);

      for (int a = 0; a < 64; a++) tile[a] = ((a / N) == (a % N)) ? 200 : 17;
      run_tile("diagonal", 1'b0, 1'b1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R3: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule